// File: doc/BRIEF.md
# Two-dimensional DMA address generator

This block turns one transfer descriptor into the sequence of burst requests that one memory side of a DMA engine must issue. A descriptor carries a start address, a row length in bytes minus one, a row count minus one and a row stride. The block walks the rows one by one. It cuts each row into bursts of at most the maximum burst size and hands each burst out as a start address plus a beat count over a valid/ready pair.

A second, independent tracker follows the data beats that the bus side reports as accepted. It keeps a live address of the next beat and a running count of the bytes moved in the current transfer. A new descriptor is taken only once every burst of the previous one has been issued and every one of its beats has been counted. A single-cycle done pulse marks the point where the last burst of the last row has been accepted.

Top module: `agen_2d`

## Requirements
- R1: After reset, desc_ready_o is 1, burst_valid_o is 0, done_o is 0, cur_addr_o is 0 and progress_o is 0.
- R2: A descriptor is taken in a cycle where desc_valid_i and desc_ready_o are both 1. From the next cycle, desc_ready_o stays 0 until every burst has been accepted and every beat has been counted. While desc_ready_o is 1, burst_valid_o is 0.
- R3: A row holds (row_len_m1 >> BUS_LOG2) + 1 beats of 2^BUS_LOG2 bytes each (8 bytes by default), so a partial last beat is rounded up to a whole beat.
- R4: A row is issued as bursts of 2^(BURST_LOG2-BUS_LOG2) beats (16 beats, 128 bytes by default), followed by one burst holding the remaining beats. Each burst within a row starts 2^BURST_LOG2 bytes after the previous one, and burst_beats_o is the plain beat count.
- R5: The first burst of each following row starts at the previous row's start address plus the stride, whatever the row length.
- R6: A row count of 0 gives exactly one row.
- R7: While burst_valid_o is 1 and burst_ready_i is 0, the request stays valid with unchanged address and beat count.
- R8: done_o is a one-cycle pulse in the cycle after the last burst of the last row is accepted, once per descriptor.
- R9: cur_addr_o loads the start address when a descriptor is taken. Each counted beat advances it by the bus width. After the last beat of a row it moves to that row's start plus the stride.
- R10: progress_o rises by the bus width in bytes on each counted beat and returns to 0 on the last beat of the transfer.
- R11: beat_i has no effect while no transfer is outstanding.
- R12: No burst is empty or longer than the maximum burst. No burst crosses a 4 KB boundary when the start address and stride are multiples of the maximum burst size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Generator idle, descriptor can be taken |
| desc_addr_i | input | ADDR_W | Start address, aligned to the bus width |
| desc_row_len_i | input | 24 | Bytes per row minus one |
| desc_rows_i | input | 24 | Number of rows minus one |
| desc_stride_i | input | 24 | Bytes from one row start to the next |
| burst_valid_o | output | 1 | Burst request valid |
| burst_ready_i | input | 1 | Burst request accepted |
| burst_addr_o | output | ADDR_W | Burst start address |
| burst_beats_o | output | BURST_LOG2-BUS_LOG2+1 | Beats in the burst |
| beat_i | input | 1 | One data beat accepted by the bus side |
| cur_addr_o | output | ADDR_W | Address of the next data beat |
| progress_o | output | 24 | Bytes moved in the current transfer |
| done_o | output | 1 | Last burst of the transfer accepted |

## Verification
The bench targets these corner cases:

- **Remainder burst.** Rows whose beat count is not a multiple of the maximum burst must end in a short remainder burst. A design that rounds the count or drops the remainder shows up as a beat-count mismatch or as an extra or missing burst.
- **Row jumps.** The stride is chosen larger than the row. A generator that carries on from the end of the previous row lands on the wrong address at the first burst of row two. The beat tracker has the same failure mode and is checked beat by beat.
- **Sub-beat rows.** A row shorter than one beat must still produce a single beat.
- **Stalls.** Long runs with burst_ready_i low catch a request that changes while stalled.
- **Progress and stray beats.** The final cycles of each transfer catch a progress counter that fails to clear. Beats pulsed while idle catch a tracker that reacts to them.
- **Back-to-back descriptors.** A second descriptor queued while the first is still running catches a ready that rises before the tracked beats are done.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int LEN_W = 24;
  typedef logic [LEN_W-1:0] len_t;
endpackage

// File: rtl/agen_burst_gen.sv
module agen_burst_gen
  import agen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_LOG2   = 3,
  parameter int BURST_LOG2 = 7,
  parameter int RB_W       = LEN_W - BUS_LOG2 + 1,
  parameter int BL_W       = BURST_LOG2 - BUS_LOG2 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [RB_W-1:0]   row_beats_i,
  input  len_t              rows_m1_i,
  input  len_t              stride_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BL_W-1:0]   beats_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [RB_W-1:0]   MAX_BEATS    = RB_W'(1) << (BURST_LOG2 - BUS_LOG2);
  localparam logic [BL_W-1:0]   MAX_BEATS_BL = BL_W'(1) << (BURST_LOG2 - BUS_LOG2);
  localparam logic [ADDR_W-1:0] BURST_BYTES  = ADDR_W'(1) << BURST_LOG2;

  logic              busy_q, done_q;
  logic [ADDR_W-1:0] row_base_q, addr_q, next_row;
  logic [RB_W-1:0]   left_q, row_beats_q;
  len_t              rows_q, stride_q;
  logic              more_in_row;

  always_comb begin
    more_in_row = left_q > MAX_BEATS;
    next_row    = row_base_q + ADDR_W'(stride_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      row_base_q  <= '0;
      addr_q      <= '0;
      left_q      <= '0;
      row_beats_q <= '0;
      rows_q      <= '0;
      stride_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q      <= 1'b1;
        row_base_q  <= base_i;
        addr_q      <= base_i;
        left_q      <= row_beats_i;
        row_beats_q <= row_beats_i;
        rows_q      <= rows_m1_i;
        stride_q    <= stride_i;
      end else if (busy_q && ready_i) begin
        if (more_in_row) begin
          addr_q <= addr_q + BURST_BYTES;
          left_q <= left_q - MAX_BEATS;
        end else if (rows_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          // rows restart from their own base, not from the last burst end
          row_base_q <= next_row;
          addr_q     <= next_row;
          left_q     <= row_beats_q;
          rows_q     <= rows_q - len_t'(1);
        end
      end
    end
  end

  assign valid_o = busy_q;
  assign addr_o  = addr_q;
  assign beats_o = more_in_row ? MAX_BEATS_BL : left_q[BL_W-1:0];
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/agen_beat_track.sv
module agen_beat_track
  import agen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BUS_LOG2 = 3,
  parameter int RB_W     = LEN_W - BUS_LOG2 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [RB_W-1:0]   row_beats_i,
  input  len_t              rows_m1_i,
  input  len_t              stride_i,
  input  logic              beat_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output len_t              progress_o
);
  localparam logic [ADDR_W-1:0] BEAT_ADDR  = ADDR_W'(1) << BUS_LOG2;
  localparam len_t              BEAT_BYTES = len_t'(1) << BUS_LOG2;

  logic              busy_q;
  logic [ADDR_W-1:0] row_base_q, cur_q, next_row;
  logic [RB_W-1:0]   left_q, row_beats_q;
  len_t              rows_q, stride_q, prog_q;

  assign next_row = row_base_q + ADDR_W'(stride_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      row_base_q  <= '0;
      cur_q       <= '0;
      left_q      <= '0;
      row_beats_q <= '0;
      rows_q      <= '0;
      stride_q    <= '0;
      prog_q      <= '0;
    end else if (start_i) begin
      busy_q      <= 1'b1;
      row_base_q  <= base_i;
      cur_q       <= base_i;
      left_q      <= row_beats_i;
      row_beats_q <= row_beats_i;
      rows_q      <= rows_m1_i;
      stride_q    <= stride_i;
      prog_q      <= '0;
    end else if (busy_q && beat_i) begin
      if (left_q == RB_W'(1)) begin
        cur_q <= next_row;
        if (rows_q == '0) begin
          busy_q <= 1'b0;
          prog_q <= '0;
        end else begin
          row_base_q <= next_row;
          left_q     <= row_beats_q;
          rows_q     <= rows_q - len_t'(1);
          prog_q     <= prog_q + BEAT_BYTES;
        end
      end else begin
        cur_q  <= cur_q + BEAT_ADDR;
        left_q <= left_q - RB_W'(1);
        prog_q <= prog_q + BEAT_BYTES;
      end
    end
  end

  assign busy_o     = busy_q;
  assign cur_addr_o = cur_q;
  assign progress_o = prog_q;
endmodule

// File: rtl/agen_2d.sv
module agen_2d
  import agen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_LOG2   = 3,
  parameter int BURST_LOG2 = 7
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           desc_valid_i,
  output logic                           desc_ready_o,
  input  logic [ADDR_W-1:0]              desc_addr_i,
  input  logic [23:0]                    desc_row_len_i,
  input  logic [23:0]                    desc_rows_i,
  input  logic [23:0]                    desc_stride_i,
  output logic                           burst_valid_o,
  input  logic                           burst_ready_i,
  output logic [ADDR_W-1:0]              burst_addr_o,
  output logic [BURST_LOG2-BUS_LOG2:0]   burst_beats_o,
  input  logic                           beat_i,
  output logic [ADDR_W-1:0]              cur_addr_o,
  output logic [23:0]                    progress_o,
  output logic                           done_o
);
  localparam int RB_W = LEN_W - BUS_LOG2 + 1;
  localparam int BL_W = BURST_LOG2 - BUS_LOG2 + 1;

  logic            start;
  logic            gen_busy, trk_busy;
  logic [RB_W-1:0] row_beats;

  assign desc_ready_o = !gen_busy && !trk_busy;
  assign start        = desc_valid_i && desc_ready_o;
  assign row_beats    = RB_W'(desc_row_len_i >> BUS_LOG2) + RB_W'(1);

  agen_burst_gen #(
    .ADDR_W(ADDR_W), .BUS_LOG2(BUS_LOG2), .BURST_LOG2(BURST_LOG2),
    .RB_W(RB_W), .BL_W(BL_W)
  ) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .base_i     (desc_addr_i),
    .row_beats_i(row_beats),
    .rows_m1_i  (desc_rows_i),
    .stride_i   (desc_stride_i),
    .ready_i    (burst_ready_i),
    .valid_o    (burst_valid_o),
    .addr_o     (burst_addr_o),
    .beats_o    (burst_beats_o),
    .busy_o     (gen_busy),
    .done_o     (done_o)
  );

  agen_beat_track #(
    .ADDR_W(ADDR_W), .BUS_LOG2(BUS_LOG2), .RB_W(RB_W)
  ) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .base_i     (desc_addr_i),
    .row_beats_i(row_beats),
    .rows_m1_i  (desc_rows_i),
    .stride_i   (desc_stride_i),
    .beat_i     (beat_i),
    .busy_o     (trk_busy),
    .cur_addr_o (cur_addr_o),
    .progress_o (progress_o)
  );
endmodule

// File: rtl/agen_2d_chk.sv
module agen_2d_chk #(
  parameter int ADDR_W     = 32,
  parameter int BUS_LOG2   = 3,
  parameter int BURST_LOG2 = 7
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         desc_valid_i,
  input logic                         desc_ready_o,
  input logic                         burst_valid_o,
  input logic                         burst_ready_i,
  input logic [ADDR_W-1:0]            burst_addr_o,
  input logic [BURST_LOG2-BUS_LOG2:0] burst_beats_o,
  input logic [23:0]                  progress_o,
  input logic                         done_o
);
  localparam int BL_W = BURST_LOG2 - BUS_LOG2 + 1;
  localparam logic [BL_W-1:0] MAX_BEATS = BL_W'(1) << (BURST_LOG2 - BUS_LOG2);

  // R2
  take_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && desc_ready_o |=> !desc_ready_o);

  // R2
  idle_no_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ready_o |-> !burst_valid_o);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && !burst_ready_i |=>
      burst_valid_o && $stable(burst_addr_o) && $stable(burst_beats_o));

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !burst_valid_o);

  // R12
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o |-> (burst_beats_o != '0) && (burst_beats_o <= MAX_BEATS));

  // R10
  idle_prog_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ready_o |-> progress_o == '0);
endmodule

bind agen_2d agen_2d_chk #(
  .ADDR_W(ADDR_W), .BUS_LOG2(BUS_LOG2), .BURST_LOG2(BURST_LOG2)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .desc_valid_i (desc_valid_i),
  .desc_ready_o (desc_ready_o),
  .burst_valid_o(burst_valid_o),
  .burst_ready_i(burst_ready_i),
  .burst_addr_o (burst_addr_o),
  .burst_beats_o(burst_beats_o),
  .progress_o   (progress_o),
  .done_o       (done_o)
);

// File: tb/agen_2d_tb.sv
module agen_2d_tb;
  localparam int ADDR_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid_i = 1'b0;
  logic        desc_ready_o;
  logic [31:0] desc_addr_i = '0;
  logic [23:0] desc_row_len_i = '0, desc_rows_i = '0, desc_stride_i = '0;
  logic        burst_valid_o;
  logic        burst_ready_i = 1'b0;
  logic [31:0] burst_addr_o;
  logic [4:0]  burst_beats_o;
  logic        beat_i = 1'b0;
  logic [31:0] cur_addr_o;
  logic [23:0] progress_o;
  logic        done_o;

  always #5 clk = ~clk;

  agen_2d #(.ADDR_W(ADDR_W), .BUS_LOG2(3), .BURST_LOG2(7)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_valid_i(desc_valid_i), .desc_ready_o(desc_ready_o),
    .desc_addr_i(desc_addr_i), .desc_row_len_i(desc_row_len_i),
    .desc_rows_i(desc_rows_i), .desc_stride_i(desc_stride_i),
    .burst_valid_o(burst_valid_o), .burst_ready_i(burst_ready_i),
    .burst_addr_o(burst_addr_o), .burst_beats_o(burst_beats_o),
    .beat_i(beat_i), .cur_addr_o(cur_addr_o), .progress_o(progress_o),
    .done_o(done_o)
  );

  int total = 0, bad = 0;
  int cyc = 0, pending = 0, done_cnt = 0, n_xfer = 0, ready_mode = 0;
  bit stray = 0;
  logic [31:0] exp_baddr_q[$];
  int          exp_bbeats_q[$];
  logic [31:0] exp_caddr_q[$];
  int          exp_prog_q[$];
  bit          hold_v = 0;
  logic [31:0] hold_a;
  logic [4:0]  hold_b;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // bus model and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (done_o) done_cnt++;
    if (rst_n) begin
      if (hold_v)
        chk(burst_valid_o && burst_addr_o == hold_a && burst_beats_o == hold_b,
            "R7", "stalled request changed", longint'(burst_addr_o), longint'(hold_a));
      case (ready_mode)
        0: burst_ready_i = 1'b1;
        1: burst_ready_i = (cyc % 3) != 1;
        default: burst_ready_i = (cyc % 5) == 0;
      endcase
      hold_v = burst_valid_o && !burst_ready_i;
      hold_a = burst_addr_o;
      hold_b = burst_beats_o;
      if (burst_valid_o && burst_ready_i) begin
        if (exp_baddr_q.size() == 0) begin
          chk(0, "R4", "unexpected burst", longint'(burst_addr_o), 0);
        end else begin
          logic [31:0] ea;
          int eb;
          ea = exp_baddr_q.pop_front();
          eb = exp_bbeats_q.pop_front();
          chk(burst_addr_o == ea, "R4", "burst addr", longint'(burst_addr_o), longint'(ea));
          chk(int'(burst_beats_o) == eb, "R3", "burst beats", longint'(burst_beats_o), longint'(eb));
          chk(int'(burst_addr_o[11:0]) + int'(burst_beats_o) * 8 <= 4096, "R12",
              "4KB crossing", longint'(burst_addr_o), 0);
        end
        pending += int'(burst_beats_o);
      end
      if (stray) begin
        beat_i = 1'b1;
      end else if (pending > 0 && (cyc % 4) != 2) begin
        logic [31:0] ec;
        int ep;
        ec = exp_caddr_q.pop_front();
        ep = exp_prog_q.pop_front();
        chk(cur_addr_o == ec, "R9", "cur addr", longint'(cur_addr_o), longint'(ec));
        chk(int'(progress_o) == ep, "R10", "progress", longint'(progress_o), longint'(ep));
        pending--;
        beat_i = 1'b1;
      end else begin
        beat_i = 1'b0;
      end
    end
  end

  // driver: push expected items, then offer the descriptor
  task automatic send(logic [31:0] a, int len_m1, int rows_m1, int stride);
    int bpr = (len_m1 >> 3) + 1;
    int prog = 0;
    for (int r = 0; r <= rows_m1; r++) begin
      logic [31:0] rb = a + 32'(r * stride);
      logic [31:0] ba = rb;
      int left = bpr;
      while (left > 0) begin
        int n = (left > 16) ? 16 : left;
        exp_baddr_q.push_back(ba);
        exp_bbeats_q.push_back(n);
        ba += 32'd128;
        left -= n;
      end
      for (int b = 0; b < bpr; b++) begin
        exp_caddr_q.push_back(rb + 32'(b * 8));
        exp_prog_q.push_back(prog);
        prog += 8;
      end
    end
    @(negedge clk);
    while (!desc_ready_o) @(negedge clk);
    desc_addr_i    = a;
    desc_row_len_i = 24'(len_m1);
    desc_rows_i    = 24'(rows_m1);
    desc_stride_i  = 24'(stride);
    desc_valid_i   = 1'b1;
    @(negedge clk);
    desc_valid_i = 1'b0;
    n_xfer++;
    chk(!desc_ready_o, "R2", "ready after take", longint'(desc_ready_o), 0);
  endtask

  task automatic wait_idle(string req, logic [31:0] exp_cur);
    @(negedge clk);
    while (!(desc_ready_o && pending == 0 && exp_baddr_q.size() == 0 &&
             exp_caddr_q.size() == 0)) @(negedge clk);
    @(negedge clk);
    chk(exp_baddr_q.size() == 0, "R4", "bursts left", longint'(exp_baddr_q.size()), 0);
    chk(cur_addr_o == exp_cur, req, "final cur addr", longint'(cur_addr_o), longint'(exp_cur));
    chk(progress_o == '0, "R10", "progress cleared", longint'(progress_o), 0);
    chk(done_cnt == n_xfer, "R8", "done pulses", longint'(done_cnt), longint'(n_xfer));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(desc_ready_o == 1'b1, "R1", "ready", longint'(desc_ready_o), 1);
    chk(!burst_valid_o, "R1", "burst valid", longint'(burst_valid_o), 0);
    chk(!done_o && cur_addr_o == '0 && progress_o == '0, "R1", "cur/prog",
        longint'(cur_addr_o), 0);

    ready_mode = 0;
    send(32'h1000, 63, 0, 'h40);           // R6 single row
    wait_idle("R6", 32'h1040);

    ready_mode = 1;
    send(32'h2000, 399, 0, 0);             // R4 16,16,16,2
    wait_idle("R6", 32'h2000);

    ready_mode = 2;
    send(32'h4000, 255, 2, 'h400);         // R5 stride beyond row
    wait_idle("R5", 32'h4C00);

    ready_mode = 1;
    send(32'h8F80, 135, 3, 'h100);         // R4 remainder of one beat
    wait_idle("R5", 32'h9380);

    ready_mode = 0;
    send(32'hA000, 4, 1, 8);               // R3 sub-beat rows
    wait_idle("R3", 32'hA010);

    // R11 stray beats while idle
    @(negedge clk);
    #1 stray = 1;
    repeat (3) @(negedge clk);
    #1 stray = 0;
    repeat (2) @(negedge clk);
    chk(cur_addr_o == 32'hA010, "R11", "cur addr after stray", longint'(cur_addr_o), 32'hA010);
    chk(progress_o == '0 && desc_ready_o, "R11", "progress after stray",
        longint'(progress_o), 0);

    ready_mode = 1;
    send(32'hC000, 127, 1, 'h80);          // R2 back to back
    send(32'hD000, 15, 0, 0);
    wait_idle("R2", 32'hD000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule